// File: doc/BRIEF.md
# Edge-Pulse Encoder with Refresh

This block is the sending half of a pulse-coded isolation link, described in synchronous logic. One logic level enters. Two one-cycle pulse lines leave it. The `up_pulse` line means "the level is now high" and the `down_pulse` line means "the level is now low". A receiver that listens to the two lines can rebuild the level on its side without a DC path. The two lines must never fire together.

A noise filter sits ahead of the edge detector. A new input level counts only once it has held for `FILT_LEN` consecutive sampled cycles, so short spikes produce nothing. Each accepted change sends one pulse of the new polarity. When the filtered level stays quiet, an idle timer starts refresh pulses that repeat the present level:
- the first refresh comes `IDLE_CYC` cycles after the last non-refresh pulse;
- later refreshes come every `REFRESH_CYC` cycles.

This lets a receiver that missed a pulse, or that powered up late, still learn a static level.

When reset is released, and again when the input-side power-good returns, the block announces its filtered level with one pulse. While power-good is low, every pulse is suppressed and the filter and timers are cleared. The filtered level itself is kept.

Top module: `pulse_edge_tx`

## Requirements
- R1: While `rst_n` is low, both pulse outputs are low. Reset sets the filtered level to 0.
- R2: An accepted change of the filtered level to 1 gives `up_pulse` high for exactly one cycle. An accepted change to 0 gives `down_pulse` high for exactly one cycle. The pulse appears in the cycle after the clock edge that samples the last qualifying input.
- R3: The input is accepted only after it has differed from the filtered level on `FILT_LEN` consecutive sampled clock edges. A shorter excursion produces no pulse and leaves the filtered level unchanged.
- R4: After any pulse that is not a refresh, the first refresh pulse comes `IDLE_CYC` cycles later, provided no change is accepted in between. An accepted change restarts this wait.
- R5: After a refresh pulse, the next refresh comes `REFRESH_CYC` cycles later. A refresh drives `up_pulse` when the filtered level is 1 and `down_pulse` when it is 0.
- R6: On the first clock edge with `rst_n` and `pwr_ok` both high, after reset or after `pwr_ok` was low, one pulse carries the filtered level. If a change is accepted on that same edge, the pulse carries the new level.
- R7: `up_pulse` and `down_pulse` are never high in the same cycle.
- R8: While `pwr_ok` is low, no pulse is produced in the following cycle. The filter count and the idle timer are cleared, and the filtered level is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Input-side power good; low suppresses pulses |
| din | input | 1 | Logic level to transmit |
| up_pulse | output | 1 | One-cycle pulse: level is high |
| down_pulse | output | 1 | One-cycle pulse: level is low |

## Verification
Every pulse is registered, so it is visible in the cycle after the edge that decides it:
- an accepted change shows one cycle after the `FILT_LEN`-th differing sample;
- the first refresh shows `IDLE_CYC` cycles after the pulse before it;
- each later refresh shows `REFRESH_CYC` cycles after the previous refresh.

The bench drives inputs on falling edges. A behavioural model works out the expected outputs at each rising edge, and both outputs are compared three time units after that edge, once the registers have settled. Each comparison names the requirement behind the expected value: filtering, acceptance, announcement, first refresh, repeated refresh, or power-down silence.

// File: rtl/pulse_edge_tx.sv
module pulse_edge_tx #(
  parameter int FILT_LEN    = 3,
  parameter int IDLE_CYC    = 100,
  parameter int REFRESH_CYC = 83
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic din,
  output logic up_pulse,
  output logic down_pulse
);
  localparam int FW   = $clog2(FILT_LEN + 1);
  localparam int TMAX = (IDLE_CYC > REFRESH_CYC) ? IDLE_CYC : REFRESH_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  logic          filt_q;
  logic [FW-1:0] hold_q;
  logic [TW-1:0] idle_q;
  logic          refr_q;
  logic          announce_q;
  logic          up_q, down_q;

  logic          accept, due, fire, level;
  logic [TW-1:0] limit;

  assign accept = (din != filt_q) && (hold_q == FW'(FILT_LEN - 1));
  assign limit  = refr_q ? TW'(REFRESH_CYC - 1) : TW'(IDLE_CYC - 1);
  assign due    = (idle_q == limit);
  assign fire   = accept | announce_q | due;
  assign level  = accept ? din : filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q     <= 1'b0;
      hold_q     <= '0;
      idle_q     <= '0;
      refr_q     <= 1'b0;
      announce_q <= 1'b1;
      up_q       <= 1'b0;
      down_q     <= 1'b0;
    end else if (!pwr_ok) begin
      hold_q     <= '0;
      idle_q     <= '0;
      refr_q     <= 1'b0;
      announce_q <= 1'b1;
      up_q       <= 1'b0;
      down_q     <= 1'b0;
    end else begin
      up_q       <= fire & level;
      down_q     <= fire & ~level;
      announce_q <= 1'b0;
      if (accept) begin
        filt_q <= din;
        hold_q <= '0;
      end else if (din != filt_q) begin
        hold_q <= hold_q + FW'(1);
      end else begin
        hold_q <= '0;
      end
      if (accept || announce_q) begin
        idle_q <= '0;
        refr_q <= 1'b0;
      end else if (due) begin
        idle_q <= '0;
        refr_q <= 1'b1;
      end else begin
        idle_q <= idle_q + TW'(1);
      end
    end
  end

  assign up_pulse   = up_q;
  assign down_pulse = down_q;
endmodule

// File: rtl/pulse_edge_tx_chk.sv
module pulse_edge_tx_chk #(
  parameter int FILT_LEN = 3
) (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok,
  input logic din,
  input logic up_pulse,
  input logic down_pulse
);
  localparam int RW = $clog2(FILT_LEN + 1);

  logic          d_q, ok_q, last_q, known_q;
  logic [RW-1:0] run_q, run_now;

  assign run_now = (din != d_q) ? RW'(1) :
                   (run_q == RW'(FILT_LEN)) ? run_q : run_q + RW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= 1'b0; run_q <= '0; ok_q <= 1'b0; last_q <= 1'b0; known_q <= 1'b0;
    end else begin
      d_q   <= din;
      run_q <= run_now;
      ok_q  <= (run_now >= RW'(FILT_LEN));
      if (up_pulse)   begin last_q <= 1'b1; known_q <= 1'b1; end
      if (down_pulse) begin last_q <= 1'b0; known_q <= 1'b1; end
    end
  end

  always_comb begin
    if (!rst_n) a_reset_quiet_r1: assert (!up_pulse && !down_pulse);
  end

  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_pulse && down_pulse));
  p_up_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    up_pulse |=> !up_pulse);
  p_down_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    down_pulse |=> !down_pulse);
  p_powered_down_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (!up_pulse && !down_pulse));
  p_rise_needs_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_pulse && known_q && !last_q) |-> (ok_q && $past(din)));
  p_fall_needs_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (down_pulse && known_q && last_q) |-> (ok_q && !$past(din)));
endmodule

bind pulse_edge_tx pulse_edge_tx_chk #(.FILT_LEN(FILT_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .din(din),
  .up_pulse(up_pulse), .down_pulse(down_pulse)
);

// File: tb/pulse_edge_tx_test.sv
module pulse_edge_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int FL = 3;
  localparam int IC = 20;
  localparam int RC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b1;
  logic din = 1'b0;
  logic up_pulse, down_pulse;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  pulse_edge_tx #(.FILT_LEN(FL), .IDLE_CYC(IC), .REFRESH_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .din(din),
    .up_pulse(up_pulse), .down_pulse(down_pulse));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_lvl, m_run, m_idle;
  bit m_inref, m_ann, e_up, e_dn;
  string why;

  always @(posedge clk) begin
    bit acc, due, fire, lv;
    if (!rst_n) begin
      m_lvl = 0; m_run = 0; m_idle = 0; m_inref = 0; m_ann = 1;
      e_up = 0; e_dn = 0; why = "R1";
    end else if (!pwr_ok) begin
      m_run = 0; m_idle = 0; m_inref = 0; m_ann = 1;
      e_up = 0; e_dn = 0; why = "R8";
    end else begin
      acc = (int'(din) != m_lvl) && (m_run + 1 >= FL);
      due = m_idle + 1 >= (m_inref ? RC : IC);
      fire = acc || m_ann || due;
      lv = acc ? din : (m_lvl != 0);
      e_up = fire && lv;
      e_dn = fire && !lv;
      if (acc) why = "R2";
      else if (m_ann) why = "R6";
      else if (due) why = m_inref ? "R5" : "R4";
      else why = "R3";
      if (acc) begin m_lvl = int'(din); m_run = 0; end
      else if (int'(din) != m_lvl) m_run++;
      else m_run = 0;
      if (acc || m_ann) begin m_idle = 0; m_inref = 0; end
      else if (due) begin m_idle = 0; m_inref = 1; end
      else m_idle++;
      m_ann = 0;
    end
  end

  always @(posedge clk) begin
    #3;
    if (!done) begin
      vectors++;
      if (up_pulse !== e_up || down_pulse !== e_dn) begin
        errors++;
        $display("FAIL %s t=%0t up/down actual=%b%b expected=%b%b",
                 why, $time, up_pulse, down_pulse, e_up, e_dn);
      end
      vectors++;
      if (up_pulse === 1'b1 && down_pulse === 1'b1) begin
        errors++;
        $display("FAIL R7 t=%0t both pulses high actual=11 expected=not both", $time);
      end
    end
  end

  task automatic hold(input bit v, input int n);
    @(negedge clk) din = v;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);          // R1 reset state compared each cycle
    rst_n = 1'b1;                      // R6 announce of level 0
    hold(0, 60);                       // R4 then R5 refreshes on down line
    hold(1, 1); hold(0, 5);            // R3 one-cycle spike
    hold(1, 2); hold(0, 30);           // R3 two-cycle spike, below FILT_LEN
    hold(1, 70);                       // R2 rise, then up-line refreshes
    hold(0, 8);                        // R2 fall
    hold(1, 15); hold(0, 15);          // R4 timer restarted by changes
    hold(1, 40);
    @(negedge clk) pwr_ok = 1'b0;      // R8 silence with input moving
    hold(0, 10); hold(1, 10); hold(0, 10);
    @(negedge clk) pwr_ok = 1'b1;      // R6 re-announce
    hold(0, 50);
    hold(1, FL); hold(0, 30);          // R3 exactly FILT_LEN accepted
    hold(1, 10);
    @(negedge clk) rst_n = 1'b0;       // R1 mid-run reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hold(1, 40);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule